// File: doc/BRIEF.md
# Transaction-layer packet receive decoder

This block sits behind a 64-bit receive datapath that hands over transaction-layer packets one beat per clock. Each beat is marked by a valid strobe, and the first and last beats of a packet are flagged. The decoder reads the header and recognises three kinds of packet with 3-dword headers: memory read requests, memory write requests and completions with data. For each recognised packet it raises a one-clock read, write or completion strobe. Alongside the strobe it presents a 64-bit data word, a quadword address (bits 63:3) and a tag. It also keeps the requester ID of the most recent accepted read, so that the completion returned later can be addressed. Any packet it does not recognise is consumed up to its last beat and produces nothing.

Completion payload arrives offset by one dword. The first payload dword sits in the low half of the second beat. The decoder therefore carries the low dword of every beat forward and joins it with the high dword of the next valid beat, and it keeps that dword through idle cycles. Requests are taken only when the base-address-hit input is high on the first beat. Completions do not look at that input.

The control is a seven-state machine:

- **IDLE** waits for a first beat.
- **RD_ADDR** expects the address beat of a read.
- **WR_ADDR** expects the address and upper data beat of a write.
- **WR_DATA** expects the lower data beat of a write.
- **CPL_HDR** expects the completion beat that holds the tag and the first payload dword.
- **CPL_DATA** emits one joined word for each further valid beat.
- **DROP** discards beats until a last beat.

Its transitions are:

- start-read, start-write, start-completion and start-drop, all leaving IDLE.
- read-done, write-done and completion-done, returning to IDLE.
- address-taken (WR_ADDR to WR_DATA) and header-taken (CPL_HDR to CPL_DATA).
- early-end, when a last beat arrives too soon and the machine returns to IDLE with no strobe.
- overrun, when a request runs past its expected last beat and the machine moves to DROP.
- drain-done, DROP back to IDLE.

Top module: `tlp_rx_decoder`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the three strobes are low and the data, address, tag and requester-ID outputs are all zero. Reset in the middle of a packet abandons that packet.
- R2: The kind of packet is decoded from the first beat. Bits 62:61 are the format and bits 60:56 are the type. Format 00 with type 00000 is a read. Format 10 with type 00000 is a write. Format 10 with type 01010 is a completion. Any other code is consumed up to the beat with the last flag and raises no strobe.
- R3: A read is two beats. The read strobe is high in the cycle after the second beat, which must carry the last flag. The address output then carries that beat's bits 63:35 as address bits 31:3, with address bits 63:32 zero. The tag output is bits 12:8 of the first beat, and the data output is zero.
- R4: A write is three beats. The write strobe is high in the cycle after the third beat, which carries the last flag. The address comes from bits 63:35 of the second beat. The data output is the second beat's bits 31:0 joined above the third beat's bits 63:32. The tag output is zero.
- R5: A completion takes its tag from bits 44:40 of its second beat. For every later valid beat it raises the completion strobe in the next cycle. The data output is the previous beat's bits 31:0 joined above this beat's bits 63:32, and the address output is zero. A 4-dword completion therefore gives two strobes and a 2-dword completion gives one.
- R6: Cycles with valid low inside a completion raise no strobe and do not disturb the carried dword. Any beat with valid low is ignored whatever its flags say.
- R7: The requester-ID output takes bits 31:16 of the first beat of an accepted read in the cycle after that beat. Writes, completions and dropped packets leave it unchanged.
- R8: A read or write whose first beat has the base-address-hit input low is consumed with no strobe and no change of requester ID. Completions are taken whatever that input is.
- R9: At most one strobe is high in any cycle, and a read or write strobe lasts a single cycle. Data, address and tag outputs keep their values between strobes.
- R10: Malformed requests raise no strobe. A request whose last flag comes before its expected final beat returns to waiting. A request still running after that beat is drained up to its last flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| beat_data | input | 64 | Packet beat; the first header dword is in bits 63:32 |
| beat_sof | input | 1 | First beat of a packet |
| beat_eof | input | 1 | Last beat of a packet |
| beat_valid | input | 1 | Beat qualifier |
| bar_hit | input | 1 | Requests address this function; sampled on the first beat |
| rd_pulse | output | 1 | Read request decoded |
| wr_pulse | output | 1 | Write request decoded |
| cpl_pulse | output | 1 | One 64-bit completion word ready |
| out_data | output | 64 | Write data or completion word; zero for reads |
| out_addr | output | 61 | Quadword address, bits 63:3 |
| out_tag | output | 5 | Request or completion tag |
| req_id | output | 16 | Requester ID of the last accepted read |

## Verification
The decoder is driven with:

- a read, then a write, then a 4-dword completion with an idle cycle between its payload beats;
- a 2-dword completion;
- a read whose tag byte has its high bits set and whose address bits are all ones.

Together these separate the three header codes. They also show whether the carried dword survives idle cycles, and whether tag masking and zero address extension are applied. Further patterns are an unrecognised format, a read with the base-address-hit input low, a completion with that input low, an over-long read, a short write and a reset mid-packet. These separate dropping, gating and early-end handling from normal decode, and they show that the requester ID changes only on accepted reads.

// File: rtl/tlp_rx_pkg.sv
package tlp_rx_pkg;

    localparam int BEAT_W  = 64;
    localparam int DW_W    = BEAT_W / 2;
    localparam int QADDR_W = BEAT_W - 3;   // quadword address bits 63:3
    localparam int ALO_W   = DW_W - 3;     // address bits 31:3 from a 3DW header

    localparam logic [1:0] FMT_HDR3_NODATA = 2'b00;
    localparam logic [1:0] FMT_HDR3_DATA   = 2'b10;
    localparam logic [4:0] TYP_MEMORY      = 5'b00000;
    localparam logic [4:0] TYP_COMPLETION  = 5'b01010;

    typedef enum logic [1:0] {
        PK_NONE,
        PK_MRD,
        PK_MWR,
        PK_CPLD
    } pkt_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ADDR,
        ST_WR_ADDR,
        ST_WR_DATA,
        ST_CPL_HDR,
        ST_CPL_DATA,
        ST_DROP
    } rx_state_e;

endpackage

// File: rtl/tlp_hdr_classify.sv
module tlp_hdr_classify
    import tlp_rx_pkg::*;
(
    input  logic [6:0] fmt_type,   // first-beat bits 62:56
    input  logic       bar_hit,
    output pkt_kind_e  kind
);
    logic [1:0] fmt;
    logic [4:0] typ;

    assign fmt = fmt_type[6:5];
    assign typ = fmt_type[4:0];

    always_comb begin
        kind = PK_NONE;
        if (fmt == FMT_HDR3_NODATA && typ == TYP_MEMORY && bar_hit)
            kind = PK_MRD;
        else if (fmt == FMT_HDR3_DATA && typ == TYP_MEMORY && bar_hit)
            kind = PK_MWR;
        else if (fmt == FMT_HDR3_DATA && typ == TYP_COMPLETION)
            kind = PK_CPLD;
    end
endmodule

// File: rtl/tlp_rx_fsm.sv
module tlp_rx_fsm
    import tlp_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      beat_valid,
    input  logic      beat_sof,
    input  logic      beat_eof,
    input  pkt_kind_e kind,
    output logic      cap_req,
    output logic      cap_wr_hi,
    output logic      cap_cpl_hdr,
    output logic      fire_rd,
    output logic      fire_wr,
    output logic      fire_cpl
);
    rx_state_e state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (beat_valid && beat_sof && !beat_eof) begin
                    unique case (kind)
                        PK_MRD:  state_nx = ST_RD_ADDR;
                        PK_MWR:  state_nx = ST_WR_ADDR;
                        PK_CPLD: state_nx = ST_CPL_HDR;
                        PK_NONE: state_nx = ST_DROP;
                    endcase
                end
            end
            ST_RD_ADDR:  if (beat_valid) state_nx = beat_eof ? ST_IDLE : ST_DROP;
            ST_WR_ADDR:  if (beat_valid) state_nx = beat_eof ? ST_IDLE : ST_WR_DATA;
            ST_WR_DATA:  if (beat_valid) state_nx = beat_eof ? ST_IDLE : ST_DROP;
            ST_CPL_HDR:  if (beat_valid) state_nx = beat_eof ? ST_IDLE : ST_CPL_DATA;
            ST_CPL_DATA: if (beat_valid && beat_eof) state_nx = ST_IDLE;
            ST_DROP:     if (beat_valid && beat_eof) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // control outputs
    always_comb begin
        cap_req     = 1'b0;
        cap_wr_hi   = 1'b0;
        cap_cpl_hdr = 1'b0;
        fire_rd     = 1'b0;
        fire_wr     = 1'b0;
        fire_cpl    = 1'b0;
        unique case (state)
            ST_IDLE:     cap_req     = beat_valid && beat_sof && !beat_eof && kind == PK_MRD;
            ST_RD_ADDR:  fire_rd     = beat_valid && beat_eof;
            ST_WR_ADDR:  cap_wr_hi   = beat_valid && !beat_eof;
            ST_WR_DATA:  fire_wr     = beat_valid && beat_eof;
            ST_CPL_HDR:  cap_cpl_hdr = beat_valid && !beat_eof;
            ST_CPL_DATA: fire_cpl    = beat_valid;
            ST_DROP:     ;
            default:     ;
        endcase
    end
endmodule

// File: rtl/tlp_rx_datapath.sv
module tlp_rx_datapath
    import tlp_rx_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int ID_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BEAT_W-1:0]  beat,
    input  logic               cap_req,
    input  logic               cap_wr_hi,
    input  logic               cap_cpl_hdr,
    input  logic               fire_rd,
    input  logic               fire_wr,
    input  logic               fire_cpl,
    output logic               rd_o,
    output logic               wr_o,
    output logic               cpl_o,
    output logic [BEAT_W-1:0]  data_o,
    output logic [QADDR_W-1:0] addr_o,
    output logic [TAG_W-1:0]   tag_o,
    output logic [ID_W-1:0]    id_o
);
    localparam int REQ_TAG_LSB = 8;    // tag within header dword 1
    localparam int CPL_TAG_LSB = 40;   // tag within completion second beat
    localparam int ID_LSB      = 16;
    localparam int ZEXT_W      = QADDR_W - ALO_W;

    logic [DW_W-1:0]  carry_dw;
    logic [ALO_W-1:0] addr_lo;
    logic [TAG_W-1:0] tag_q;
    logic [DW_W-1:0]  beat_hi;
    logic [DW_W-1:0]  beat_lo;

    assign beat_hi = beat[BEAT_W-1:DW_W];
    assign beat_lo = beat[DW_W-1:0];

    // packet-scoped capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_dw <= '0;
            addr_lo  <= '0;
            tag_q    <= '0;
            id_o     <= '0;
        end else begin
            if (cap_req) begin
                id_o  <= beat[ID_LSB +: ID_W];
                tag_q <= beat[REQ_TAG_LSB +: TAG_W];
            end
            if (cap_wr_hi) begin
                addr_lo  <= beat[BEAT_W-1:BEAT_W-ALO_W];
                carry_dw <= beat_lo;
            end
            if (cap_cpl_hdr) begin
                tag_q    <= beat[CPL_TAG_LSB +: TAG_W];
                carry_dw <= beat_lo;
            end
            if (fire_cpl)
                carry_dw <= beat_lo;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_o   <= 1'b0;
            wr_o   <= 1'b0;
            cpl_o  <= 1'b0;
            data_o <= '0;
            addr_o <= '0;
            tag_o  <= '0;
        end else begin
            rd_o  <= fire_rd;
            wr_o  <= fire_wr;
            cpl_o <= fire_cpl;
            if (fire_rd) begin
                data_o <= '0;
                addr_o <= {{ZEXT_W{1'b0}}, beat[BEAT_W-1:BEAT_W-ALO_W]};
                tag_o  <= tag_q;
            end else if (fire_wr) begin
                data_o <= {carry_dw, beat_hi};
                addr_o <= {{ZEXT_W{1'b0}}, addr_lo};
                tag_o  <= '0;
            end else if (fire_cpl) begin
                data_o <= {carry_dw, beat_hi};
                addr_o <= '0;
                tag_o  <= tag_q;
            end
        end
    end
endmodule

// File: rtl/tlp_rx_decoder.sv
module tlp_rx_decoder
    import tlp_rx_pkg::*;
#(
    parameter int TAG_W = 5,
    parameter int ID_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BEAT_W-1:0]  beat_data,
    input  logic               beat_sof,
    input  logic               beat_eof,
    input  logic               beat_valid,
    input  logic               bar_hit,
    output logic               rd_pulse,
    output logic               wr_pulse,
    output logic               cpl_pulse,
    output logic [BEAT_W-1:0]  out_data,
    output logic [QADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]   out_tag,
    output logic [ID_W-1:0]    req_id
);
    pkt_kind_e kind;
    logic cap_req, cap_wr_hi, cap_cpl_hdr;
    logic fire_rd, fire_wr, fire_cpl;

    tlp_hdr_classify u_cls (
        .fmt_type (beat_data[62:56]),
        .bar_hit  (bar_hit),
        .kind     (kind)
    );

    tlp_rx_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat_valid  (beat_valid),
        .beat_sof    (beat_sof),
        .beat_eof    (beat_eof),
        .kind        (kind),
        .cap_req     (cap_req),
        .cap_wr_hi   (cap_wr_hi),
        .cap_cpl_hdr (cap_cpl_hdr),
        .fire_rd     (fire_rd),
        .fire_wr     (fire_wr),
        .fire_cpl    (fire_cpl)
    );

    tlp_rx_datapath #(.TAG_W(TAG_W), .ID_W(ID_W)) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .beat        (beat_data),
        .cap_req     (cap_req),
        .cap_wr_hi   (cap_wr_hi),
        .cap_cpl_hdr (cap_cpl_hdr),
        .fire_rd     (fire_rd),
        .fire_wr     (fire_wr),
        .fire_cpl    (fire_cpl),
        .rd_o        (rd_pulse),
        .wr_o        (wr_pulse),
        .cpl_o       (cpl_pulse),
        .data_o      (out_data),
        .addr_o      (out_addr),
        .tag_o       (out_tag),
        .id_o        (req_id)
    );
endmodule

// File: rtl/tlp_rx_checker.sv
module tlp_rx_checker #(
    parameter int TAG_W   = 5,
    parameter int ID_W    = 16,
    parameter int QADDR_W = 61
) (
    input logic               clk,
    input logic               rst_n,
    input logic               beat_valid,
    input logic               beat_sof,
    input logic               beat_eof,
    input logic               bar_hit,
    input logic               rd_pulse,
    input logic               wr_pulse,
    input logic               cpl_pulse,
    input logic [QADDR_W-1:0] out_addr,
    input logic [TAG_W-1:0]   out_tag,
    input logic [ID_W-1:0]    req_id
);
    a_r9_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_pulse, wr_pulse, cpl_pulse}));

    a_r9_rd_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |=> !rd_pulse);

    a_r9_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);

    a_r3_rd_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        rd_pulse |-> $past(beat_valid && beat_eof));

    a_r4_wr_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> $past(beat_valid && beat_eof));

    a_r4_wr_tag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |-> out_tag == '0);

    a_r5_cpl_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_pulse |-> out_addr == '0);

    a_r6_cpl_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_pulse |-> $past(beat_valid));

    a_r7_id_on_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(req_id) |-> $past(beat_valid && beat_sof && bar_hit));
endmodule

bind tlp_rx_decoder tlp_rx_checker #(
    .TAG_W   (TAG_W),
    .ID_W    (ID_W),
    .QADDR_W (tlp_rx_pkg::QADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat_valid (beat_valid),
    .beat_sof   (beat_sof),
    .beat_eof   (beat_eof),
    .bar_hit    (bar_hit),
    .rd_pulse   (rd_pulse),
    .wr_pulse   (wr_pulse),
    .cpl_pulse  (cpl_pulse),
    .out_addr   (out_addr),
    .out_tag    (out_tag),
    .req_id     (req_id)
);

// File: tb/tb_tlp_rx_decoder.sv
module tb_tlp_rx_decoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] beat_data = '0;
    logic        beat_sof = 1'b0, beat_eof = 1'b0, beat_valid = 1'b0, bar_hit = 1'b0;
    logic        rd_pulse, wr_pulse, cpl_pulse;
    logic [63:0] out_data;
    logic [60:0] out_addr;
    logic [4:0]  out_tag;
    logic [15:0] req_id;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;   // 50 MHz

    tlp_rx_decoder dut (
        .clk(clk), .rst_n(rst_n), .beat_data(beat_data), .beat_sof(beat_sof),
        .beat_eof(beat_eof), .beat_valid(beat_valid), .bar_hit(bar_hit),
        .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .cpl_pulse(cpl_pulse),
        .out_data(out_data), .out_addr(out_addr), .out_tag(out_tag), .req_id(req_id)
    );

    typedef struct packed {
        logic        v, s, e, b;
        logic [63:0] beat;
        logic        x_rd, x_wr, x_cpl, chk;
        logic [63:0] x_data;
        logic [60:0] x_addr;
        logic [4:0]  x_tag;
        logic [15:0] x_id;
        logic [3:0]  grp;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        // idle after reset
        '{1'b0,1'b0,1'b0,1'b1, 64'h0, 1'b0,1'b0,1'b0,1'b1, 64'h0, 61'd0, 5'h00, 16'h0000, 4'd0},
        // read header, id AAAA tag 0A (R7)
        '{1'b1,1'b1,1'b0,1'b1, 64'h00000002_AAAA0AFF, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd6},
        // read address 1, last (R3)
        '{1'b1,1'b0,1'b1,1'b1, 64'h00000008_00000000, 1'b1,1'b0,1'b0,1'b1, 64'h0, 61'd1, 5'h0A, 16'hAAAA, 4'd2},
        // write header, id BBBB must not latch
        '{1'b1,1'b1,1'b0,1'b1, 64'h40000002_BBBB00FF, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd6},
        '{1'b1,1'b0,1'b0,1'b1, 64'h00000010_AAAAAAAA, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd3},
        // write last beat (R4)
        '{1'b1,1'b0,1'b1,1'b1, 64'hAAAAAAAA_00000000, 1'b0,1'b1,1'b0,1'b1, 64'hAAAAAAAA_AAAAAAAA, 61'd2, 5'h00, 16'hAAAA, 4'd3},
        '{1'b0,1'b0,1'b0,1'b1, 64'h0, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd0},
        // completion, 4 dwords, bar low (R8, R5)
        '{1'b1,1'b1,1'b0,1'b0, 64'h4A000004_BBBB0004, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd7},
        '{1'b1,1'b0,1'b0,1'b0, 64'hBBBB0B00_AAAAAAAA, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd4},
        '{1'b1,1'b0,1'b0,1'b0, 64'hAAAAAAAA_BBBBBBBB, 1'b0,1'b0,1'b1,1'b1, 64'hAAAAAAAA_AAAAAAAA, 61'd0, 5'h0B, 16'hAAAA, 4'd4},
        // idle inside completion, flags set with valid low (R6)
        '{1'b0,1'b1,1'b1,1'b1, 64'hFFFFFFFF_FFFFFFFF, 1'b0,1'b0,1'b0,1'b1, 64'hAAAAAAAA_AAAAAAAA, 61'd0, 5'h0B, 16'hAAAA, 4'd5},
        '{1'b1,1'b0,1'b1,1'b0, 64'hBBBBBBBB_01234567, 1'b0,1'b0,1'b1,1'b1, 64'hBBBBBBBB_BBBBBBBB, 61'd0, 5'h0B, 16'hAAAA, 4'd5},
        // unrecognised format 01 (R2)
        '{1'b1,1'b1,1'b0,1'b1, 64'h20000001_CCCC05FF, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd1},
        '{1'b1,1'b0,1'b0,1'b1, 64'h00000018_00000000, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd1},
        '{1'b1,1'b0,1'b1,1'b1, 64'h00000020_11111111, 1'b0,1'b0,1'b0,1'b1, 64'hBBBBBBBB_BBBBBBBB, 61'd0, 5'h0B, 16'hAAAA, 4'd1},
        // read with bar low: ignored (R8)
        '{1'b1,1'b1,1'b0,1'b0, 64'h00000002_CCCC07FF, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hAAAA, 4'd7},
        '{1'b1,1'b0,1'b1,1'b0, 64'h00000018_00000000, 1'b0,1'b0,1'b0,1'b1, 64'hBBBBBBBB_BBBBBBBB, 61'd0, 5'h0B, 16'hAAAA, 4'd7},
        // read with bar high, id CCCC tag 07 addr 3
        '{1'b1,1'b1,1'b0,1'b1, 64'h00000002_CCCC07FF, 1'b0,1'b0,1'b0,1'b0, 64'h0, 61'd0, 5'h00, 16'hCCCC, 4'd6},
        '{1'b1,1'b0,1'b1,1'b1, 64'h00000018_00000000, 1'b1,1'b0,1'b0,1'b1, 64'h0, 61'd3, 5'h07, 16'hCCCC, 4'd2}
    };

    function automatic string grp_name(input logic [3:0] g);
        case (g)
            4'd1:    return "R2";
            4'd2:    return "R3";
            4'd3:    return "R4";
            4'd4:    return "R5";
            4'd5:    return "R6";
            4'd6:    return "R7";
            4'd7:    return "R8";
            default: return "R9";
        endcase
    endfunction

    // drive one beat at a falling edge, then land on the next falling edge
    task automatic drive(input logic v, s, e, b, input logic [63:0] d);
        beat_valid = v; beat_sof = s; beat_eof = e; bar_hit = b; beat_data = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic x_rd, x_wr, x_cpl, chk,
                              input logic [63:0] x_d, input logic [60:0] x_a,
                              input logic [4:0] x_t, input logic [15:0] x_id);
        logic bad;
        n_tests++;
        bad = (rd_pulse !== x_rd) || (wr_pulse !== x_wr) || (cpl_pulse !== x_cpl) ||
              (req_id !== x_id);
        if (chk)
            bad = bad || (out_data !== x_d) || (out_addr !== x_a) || (out_tag !== x_t);
        if (bad) begin
            n_fail++;
            $display("FAIL %s: got rd=%b wr=%b cpl=%b data=%h addr=%h tag=%h id=%h, expected rd=%b wr=%b cpl=%b data=%h addr=%h tag=%h id=%h",
                     req, rd_pulse, wr_pulse, cpl_pulse, out_data, out_addr, out_tag, req_id,
                     x_rd, x_wr, x_cpl, x_d, x_a, x_t, x_id);
        end
    endtask

    initial begin
        #(20 * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: got no end of run, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 0,0,0,1, 64'h0, 61'd0, 5'h0, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1 after release", 0,0,0,1, 64'h0, 61'd0, 5'h0, 16'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].v, VECS[i].s, VECS[i].e, VECS[i].b, VECS[i].beat);
            expect_out(grp_name(VECS[i].grp), VECS[i].x_rd, VECS[i].x_wr, VECS[i].x_cpl,
                       VECS[i].chk, VECS[i].x_data, VECS[i].x_addr, VECS[i].x_tag, VECS[i].x_id);
        end

        // R10: over-long read is drained, no strobe; the id is latched by the accepted first beat
        drive(1,1,0,1, 64'h00000002_DDDD03FF);
        expect_out("R10 long read hdr", 0,0,0,1, 64'h0, 61'd3, 5'h07, 16'hDDDD);
        drive(1,0,0,1, 64'h00000028_00000000);
        expect_out("R10 long read beat2", 0,0,0,1, 64'h0, 61'd3, 5'h07, 16'hDDDD);
        drive(1,0,1,1, 64'h0);
        expect_out("R10 long read last", 0,0,0,1, 64'h0, 61'd3, 5'h07, 16'hDDDD);

        // R10: short write, no strobe; R7: write header id not taken
        drive(1,1,0,1, 64'h40000002_EEEE00FF);
        drive(1,0,1,1, 64'h00000030_12345678);
        expect_out("R10 short write", 0,0,0,1, 64'h0, 61'd3, 5'h07, 16'hDDDD);

        // R5: 2-dword completion gives one word, tag 1F
        drive(1,1,0,0, 64'h4A000002_EEEE0004);
        drive(1,0,0,0, 64'hEEEE1F00_12345678);
        expect_out("R5 cpl2 header beat", 0,0,0,1, 64'h0, 61'd3, 5'h07, 16'hDDDD);
        drive(1,0,1,0, 64'h9ABCDEF0_00000000);
        expect_out("R5 cpl2 word", 0,0,1,1, 64'h12345678_9ABCDEF0, 61'd0, 5'h1F, 16'hDDDD);
        drive(0,0,0,0, 64'h0);
        expect_out("R9 hold after cpl", 0,0,0,1, 64'h12345678_9ABCDEF0, 61'd0, 5'h1F, 16'hDDDD);

        // R3: tag masked to 5 bits, all-ones address bits 31:3, upper address zero
        drive(1,1,0,1, 64'h00000002_1234E5FF);
        expect_out("R7 id 1234", 0,0,0,0, 64'h0, 61'd0, 5'h0, 16'h1234);
        drive(1,0,1,1, 64'hFFFFFFF8_00000000);
        expect_out("R3 masked tag", 1,0,0,1, 64'h0, 61'h1FFF_FFFF, 5'h05, 16'h1234);
        drive(0,0,0,1, 64'h0);
        expect_out("R9 rd single cycle", 0,0,0,1, 64'h0, 61'h1FFF_FFFF, 5'h05, 16'h1234);

        // R1: reset mid-write abandons it
        drive(1,1,0,1, 64'h40000002_FFFF00FF);
        rst_n = 1'b0;
        @(negedge clk);
        expect_out("R1 reset mid packet", 0,0,0,1, 64'h0, 61'd0, 5'h0, 16'h0);
        rst_n = 1'b1;
        drive(1,0,0,1, 64'h00000040_55555555);
        drive(1,0,1,1, 64'h55555555_00000000);
        expect_out("R1 abandoned write", 0,0,0,1, 64'h0, 61'd0, 5'h0, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule